// File: doc/BRIEF.md
# Link Instruction Sequencer

This block is the instruction engine of a serial display host's lane controller. Software fills sixteen instruction slots with function words and writes a successor table. It can also set one counted conditional jump and two delay counts. A start command then walks the chain from slot 0. On every step the block presents the active slot number and its function word, together with a one-cycle strobe. The lane logic downstream turns each function word into actual signalling, which is not part of this block.

Each slot names its successor through a 4-bit field in a 64-bit select table. Successor 15 marks the end of the chain. A slot whose mode is no-op acts as a delay, and its length comes from one of the two loop counts. The start bit stays set for as long as the walk runs and clears itself when the end code is reached. Writing zero to the start bit aborts the walk. A walk that never reaches the end code is stopped after a fixed number of steps and raises a sticky error.

Top module: `link_seq_top`

## Requirements
- R1: After reset, busy_o, done_o, err_o and step_o are 0. Slot registers (addresses 0 to 15), the jump register (18), the loop register (19) and the control register (20) read 0. Both select words (16, 17) read 0xFFFFFFFF.
- R2: A slot word has its mode in [31:28], escape entry in [27:24], packet kind in [23:20], clock-lane enable in bit 4 and data-lane enables in [3:0]. The mode codes are stop 0, turnaround 1, high-speed 2, escape 3, clock exit 4 and no-op 5. The escape codes are low-power data 0, ultra-low-power 1 and reset 4. The packet kinds are pixel 0 and command 1. Slots read back as written, and func_o equals the word of the slot shown on slot_o while step_o is high.
- R3: Writing 1 to bit 0 of the control register (address 20) makes busy_o 1, step_o 1 and slot_o 0 in the next cycle.
- R4: The successor of slot k is the nibble at bits [4k+3:4k] of the 64-bit select table. Address 16 holds slots 0 to 7 and address 17 holds slots 8 to 15. A slot that is not a delay lasts exactly one cycle.
- R5: When the successor is 15, busy_o falls and done_o pulses for one cycle in the cycle after the last slot. Control bit 0 then reads 0.
- R6: A slot with mode no-op lasts count+1 cycles. The first delay in a walk uses N0 (address 19, bits [11:0]). Every later delay in the same walk uses N1 (bits [27:16]).
- R7: The jump register (address 18) holds a count in [15:0], a jump point in [19:16] and a target in [23:20]. The count is loaded at start. Each time the jump-point slot finishes with count left, control goes to the target and the count drops by one.
- R8: With a jump count of 0, the jump point always follows its select-table successor.
- R9: Writing 0 to control bit 0 during a walk clears busy_o in the next cycle with no done_o pulse, and no further strobes follow.
- R10: A walk that issues 64 strobes without reaching code 15 stops with no done_o. It sets err_o, which also reads as control bit 1. The flag stays set until the next start.
- R11: step_o is high for exactly one cycle per executed slot and is never high while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| busy_o | output | 1 | Walk in progress; the start bit as read back |
| done_o | output | 1 | One-cycle pulse on reaching the end code |
| err_o | output | 1 | Sticky step-limit error |
| step_o | output | 1 | One-cycle strobe per executed slot |
| slot_o | output | 4 | Active slot number |
| func_o | output | 32 | Active slot function word |

## Verification
A start or abort write takes effect at the clock edge that samples it, and its result is visible in the first cycle after that edge. Each following cycle then shows either the next slot or, for a delay, the same slot again. The end of a walk shows busy_o low and done_o high one cycle after the last slot cycle. The bench drives and samples on the falling edge. It counts the cycles of busy_o, records slot_o on each strobe and compares the trace and the cycle total against values derived from the successor, jump and delay rules. Read-back through the combinational read port is sampled 1 ns after the address is set.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
  localparam int ID_W   = 4;
  localparam int NSLOT  = 1 << ID_W;
  localparam int WORD_W = 32;
  localparam int LOOP_W = 12;
  localparam int JCNT_W = 16;

  localparam int A_JSEL_LO = NSLOT;
  localparam int JSEL_WORDS = NSLOT * ID_W / WORD_W;
  localparam int A_JCFG = A_JSEL_LO + JSEL_WORDS;
  localparam int A_LOOP = A_JCFG + 1;
  localparam int A_CTRL = A_LOOP + 1;
  localparam int ADDR_W = $clog2(A_CTRL + 1);

  localparam logic [ID_W-1:0] ID_END = '1;

  typedef enum logic [3:0] {
    MODE_STOP = 4'd0,
    MODE_TURN = 4'd1,
    MODE_HS   = 4'd2,
    MODE_ESC  = 4'd3,
    MODE_HSX  = 4'd4,
    MODE_NOP  = 4'd5
  } mode_e;

  localparam logic [3:0] ESC_LPDT = 4'd0;
  localparam logic [3:0] ESC_ULP  = 4'd1;
  localparam logic [3:0] ESC_RST  = 4'd4;
  localparam logic [3:0] PKT_PIX  = 4'd0;
  localparam logic [3:0] PKT_CMD  = 4'd1;

  typedef struct packed {
    logic [3:0]  mode;
    logic [3:0]  esc;
    logic [3:0]  pkt;
    logic [14:0] rsvd;
    logic        clk_en;
    logic [3:0]  lane_en;
  } func_t;
endpackage

// File: rtl/link_seq_regs.sv
module link_seq_regs
  import link_seq_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [WORD_W-1:0]              wr_data_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  input  logic                           busy_i,
  input  logic                           err_i,
  output logic [WORD_W-1:0]              rd_data_o,
  output logic [NSLOT-1:0][WORD_W-1:0]   slot_tbl_o,
  output logic [NSLOT*ID_W-1:0]          jsel_o,
  output logic [WORD_W-1:0]              jcfg_o,
  output logic [WORD_W-1:0]              loop_o,
  output logic                           start_o,
  output logic                           abort_o
);
  logic [NSLOT-1:0][WORD_W-1:0]      slot_q;
  logic [JSEL_WORDS-1:0][WORD_W-1:0] jsel_q;
  logic [WORD_W-1:0]                 jcfg_q, loop_q;
  logic                              ctrl_wr;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[g] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(g)) slot_q[g] <= wr_data_i;
    end
  end

  // reset successors to END so a bare start runs slot 0 only
  for (genvar w = 0; w < JSEL_WORDS; w++) begin : g_jsel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) jsel_q[w] <= '1;
      else if (wr_en_i && wr_addr_i == ADDR_W'(A_JSEL_LO + w)) jsel_q[w] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jcfg_q <= '0;
      loop_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(A_JCFG)) jcfg_q <= wr_data_i;
      if (wr_addr_i == ADDR_W'(A_LOOP)) loop_q <= wr_data_i;
    end
  end

  assign ctrl_wr = wr_en_i && wr_addr_i == ADDR_W'(A_CTRL);
  assign start_o = ctrl_wr && wr_data_i[0];
  assign abort_o = ctrl_wr && !wr_data_i[0];

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(NSLOT)) rd_data_o = slot_q[rd_addr_i[ID_W-1:0]];
    for (int w = 0; w < JSEL_WORDS; w++)
      if (rd_addr_i == ADDR_W'(A_JSEL_LO + w)) rd_data_o = jsel_q[w];
    if (rd_addr_i == ADDR_W'(A_JCFG)) rd_data_o = jcfg_q;
    if (rd_addr_i == ADDR_W'(A_LOOP)) rd_data_o = loop_q;
    if (rd_addr_i == ADDR_W'(A_CTRL)) rd_data_o = {{(WORD_W-2){1'b0}}, err_i, busy_i};
  end

  assign slot_tbl_o = slot_q;
  assign jsel_o     = jsel_q;
  assign jcfg_o     = jcfg_q;
  assign loop_o     = loop_q;
endmodule

// File: rtl/link_seq_next.sv
module link_seq_next
  import link_seq_pkg::*;
(
  input  logic [ID_W-1:0]       cur_i,
  input  logic [NSLOT*ID_W-1:0] jsel_i,
  input  logic [ID_W-1:0]       jpt_i,
  input  logic [ID_W-1:0]       jtgt_i,
  input  logic [JCNT_W-1:0]     jleft_i,
  output logic [ID_W-1:0]       nxt_o,
  output logic                  take_o
);
  assign take_o = (cur_i == jpt_i) && (jleft_i != '0);
  assign nxt_o  = take_o ? jtgt_i : jsel_i[cur_i*ID_W +: ID_W];
endmodule

// File: rtl/link_seq_ctrl.sv
module link_seq_ctrl
  import link_seq_pkg::*;
#(
  parameter int MAX_STEPS = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         abort_i,
  input  logic [NSLOT-1:0][WORD_W-1:0] slot_tbl_i,
  input  logic [ID_W-1:0]              nxt_i,
  input  logic                         take_i,
  input  logic [JCNT_W-1:0]            jcnt_i,
  input  logic [LOOP_W-1:0]            n0_i,
  input  logic [LOOP_W-1:0]            n1_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         err_o,
  output logic                         step_o,
  output logic [ID_W-1:0]              slot_o,
  output logic [WORD_W-1:0]            func_o,
  output logic [JCNT_W-1:0]            jleft_o
);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);

  logic              busy_q, done_q, err_q, step_q, dly_seen_q;
  logic [ID_W-1:0]   cur_q;
  logic [WORD_W-1:0] func_q;
  logic [LOOP_W-1:0] dly_q;
  logic [STEP_W-1:0] steps_q;
  logic [JCNT_W-1:0] jleft_q;

  logic [ID_W-1:0]   ld_id;
  func_t             ld_func;
  logic              ld_nop;
  logic [LOOP_W-1:0] ld_dly;

  // word of the slot about to be entered, and its delay length
  assign ld_id   = start_i ? '0 : nxt_i;
  assign ld_func = func_t'(slot_tbl_i[ld_id]);
  assign ld_nop  = ld_func.mode == MODE_NOP;
  assign ld_dly  = !ld_nop ? '0 : (dly_seen_q && !start_i) ? n1_i : n0_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      step_q     <= 1'b0;
      dly_seen_q <= 1'b0;
      cur_q      <= '0;
      func_q     <= '0;
      dly_q      <= '0;
      steps_q    <= '0;
      jleft_q    <= '0;
    end else begin
      step_q <= 1'b0;
      done_q <= 1'b0;
      if (start_i) begin
        busy_q     <= 1'b1;
        err_q      <= 1'b0;
        step_q     <= 1'b1;
        cur_q      <= ld_id;
        func_q     <= ld_func;
        dly_q      <= ld_dly;
        dly_seen_q <= ld_nop;
        steps_q    <= STEP_W'(1);
        jleft_q    <= jcnt_i;
      end else if (abort_i) begin
        busy_q <= 1'b0;
        dly_q  <= '0;
      end else if (busy_q) begin
        if (dly_q != '0) begin
          dly_q <= dly_q - 1'b1;
        end else if (nxt_i == ID_END) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (steps_q == STEP_W'(MAX_STEPS)) begin
          busy_q <= 1'b0;
          err_q  <= 1'b1;
        end else begin
          step_q  <= 1'b1;
          cur_q   <= ld_id;
          func_q  <= ld_func;
          dly_q   <= ld_dly;
          steps_q <= steps_q + 1'b1;
          if (ld_nop) dly_seen_q <= 1'b1;
          if (take_i) jleft_q <= jleft_q - 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign step_o  = step_q;
  assign slot_o  = cur_q;
  assign func_o  = func_q;
  assign jleft_o = jleft_q;
endmodule

// File: rtl/link_seq_top.sv
module link_seq_top
  import link_seq_pkg::*;
#(
  parameter int MAX_STEPS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              step_o,
  output logic [ID_W-1:0]   slot_o,
  output logic [WORD_W-1:0] func_o
);
  logic [NSLOT-1:0][WORD_W-1:0] slot_tbl;
  logic [NSLOT*ID_W-1:0]        jsel;
  logic [WORD_W-1:0]            jcfg, loop_w;
  logic                         start, abort, take;
  logic [ID_W-1:0]              nxt;
  logic [JCNT_W-1:0]            jleft;

  link_seq_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .busy_i     (busy_o),
    .err_i      (err_o),
    .rd_data_o  (rd_data_o),
    .slot_tbl_o (slot_tbl),
    .jsel_o     (jsel),
    .jcfg_o     (jcfg),
    .loop_o     (loop_w),
    .start_o    (start),
    .abort_o    (abort)
  );

  link_seq_next u_next (
    .cur_i   (slot_o),
    .jsel_i  (jsel),
    .jpt_i   (jcfg[19:16]),
    .jtgt_i  (jcfg[23:20]),
    .jleft_i (jleft),
    .nxt_o   (nxt),
    .take_o  (take)
  );

  link_seq_ctrl #(.MAX_STEPS(MAX_STEPS)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .abort_i    (abort),
    .slot_tbl_i (slot_tbl),
    .nxt_i      (nxt),
    .take_i     (take),
    .jcnt_i     (jcfg[JCNT_W-1:0]),
    .n0_i       (loop_w[LOOP_W-1:0]),
    .n1_i       (loop_w[16 +: LOOP_W]),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .step_o     (step_o),
    .slot_o     (slot_o),
    .func_o     (func_o),
    .jleft_o    (jleft)
  );
endmodule

// File: rtl/link_seq_chk.sv
module link_seq_chk
  import link_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              step_o,
  input logic [ID_W-1:0]   slot_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && wr_addr_i == ADDR_W'(A_CTRL);

  // R3
  start_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && wr_data_i[0] |=> busy_o && step_o && slot_o == '0);

  // R5
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o) && !step_o);

  // R9
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wr_data_i[0] |=> !busy_o && !step_o && !done_o);

  // R10
  err_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o && $past(busy_o) && !done_o);

  // R11
  step_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> busy_o && slot_o != ID_END);
endmodule

bind link_seq_top link_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .step_o    (step_o),
  .slot_o    (slot_o)
);

// File: tb/tb_link_seq_top.sv
`timescale 1ns/1ps
module tb_link_seq_top;
  import link_seq_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [WORD_W-1:0] wr_data, rd_data, func;
  logic              busy, done, err, step;
  logic [ID_W-1:0]   slot;

  link_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .err_o(err), .step_o(step),
    .slot_o(slot), .func_o(func)
  );

  int checks = 0, errors = 0;

  // {sel_lo, sel_hi, jump, loop, steps[7:0], trace nibbles[31:0], cycles[15:0]}
  localparam logic [183:0] VEC [5] = '{
    {32'hFFFFFFF4, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 8'd2, 32'h00000040, 16'd2},
    {32'h1FF7FFF4, 32'hFFFFFFFF, 32'h00000000, 32'h00050003, 8'd4, 32'h00001740, 16'd7},
    {32'h2FFFFFF7, 32'hFFFFFFFF, 32'h00720001, 32'h00050003, 8'd5, 32'h00027270, 16'd13},
    {32'h2FFFFFF7, 32'hFFFFFFFF, 32'h00720000, 32'h00050003, 8'd3, 32'h00000270, 16'd6},
    {32'hFFFFFFF9, 32'hFFFFFFEF, 32'h00000000, 32'h00000000, 8'd3, 32'h00000E90, 16'd3}
  };
  localparam string VREQ [5] = '{"R4", "R6", "R7", "R8", "R4"};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] efunc(input int k);
    logic [3:0] m, e;
    m = (k == 7) ? 4'(MODE_NOP) : 4'(k % 5);
    e = (k == 4) ? ESC_LPDT : (k == 5) ? ESC_ULP : (k == 6) ? ESC_RST : 4'd0;
    return {m, e, (k[0] ? PKT_CMD : PKT_PIX), 15'd0, k[1], 4'(k)};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    rd_addr = ADDR_W'(a);
    #1 d = rd_data;
  endtask

  task automatic walk(output int n, output logic [31:0] tr, output int cyc,
                      output logic fdone, output bit fok);
    n = 0; tr = '0; cyc = 0; fok = 1;
    while (busy && cyc < 2000) begin
      if (step) begin
        if (n < 8) tr[4*n +: 4] = slot;
        if (func !== efunc(int'(slot))) fok = 0;
        n++;
      end
      cyc++;
      @(negedge clk);
    end
    fdone = done;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, tr;
    int n, cyc;
    logic fd;
    bit fok;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, err, step} == 4'b0, "R1", "status after reset", {busy, done, err, step}, 0);
    rd(A_CTRL, d);    chk(d == 0, "R1", "control after reset", d, 0);
    rd(3, d);         chk(d == 0, "R1", "slot after reset", d, 0);
    rd(A_JSEL_LO, d); chk(d == 32'hFFFFFFFF, "R1", "select after reset", d, 32'hFFFFFFFF);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NSLOT; k++) wr(k, efunc(k));
    rd(9, d); chk(d == efunc(9), "R2", "slot 9 readback", d, efunc(9));
    rd(7, d); chk(d[31:28] == 4'(MODE_NOP), "R2", "slot 7 mode field", d[31:28], 5);

    for (int v = 0; v < 5; v++) begin
      wr(A_JSEL_LO, VEC[v][183:152]);
      wr(A_JSEL_LO + 1, VEC[v][151:120]);
      wr(A_JCFG, VEC[v][119:88]);
      wr(A_LOOP, VEC[v][87:56]);
      wr(A_CTRL, 32'd1);
      // R3
      chk(busy && step && slot == 0, "R3", "launch at slot 0", {busy, step, slot}, 6'b110000);
      walk(n, tr, cyc, fd, fok);
      chk(n == int'(VEC[v][55:48]), VREQ[v], "strobe count", n, VEC[v][55:48]);
      chk(tr == VEC[v][47:16], VREQ[v], "slot trace", tr, VEC[v][47:16]);
      // R6 cycle totals include delay slots
      chk(cyc == int'(VEC[v][15:0]), "R6", "walk cycles", cyc, VEC[v][15:0]);
      chk(fd == 1'b1, "R5", "done pulse at end", fd, 1);
      chk(fok, "R2", "func word on each strobe", fok, 1);
      rd(A_CTRL, d); chk(d[0] == 1'b0, "R5", "start bit self-cleared", d[0], 0);
    end

    // R11 idle: no strobes, done was a single cycle
    @(negedge clk);
    chk(!step && !done, "R11", "idle after done", {step, done}, 0);

    // R9 abort mid-walk
    wr(A_JSEL_LO, 32'h1FF7FFF4); wr(A_JSEL_LO + 1, 32'hFFFFFFFF);
    wr(A_JCFG, 32'd0); wr(A_LOOP, 32'h00050003);
    wr(A_CTRL, 32'd1);
    @(negedge clk);
    wr(A_CTRL, 32'd0);
    chk(!busy && !step && !done, "R9", "abort stops walk", {busy, step, done}, 0);
    @(negedge clk);
    chk(!busy && !step && !done, "R9", "no activity after abort", {busy, step, done}, 0);

    // R10 runaway 0->1->0
    wr(A_JSEL_LO, 32'hFFFFFF01);
    wr(A_CTRL, 32'd1);
    walk(n, tr, cyc, fd, fok);
    chk(n == 64, "R10", "strobes before limit", n, 64);
    chk(err && !fd, "R10", "error set, no done", {err, fd}, 2'b10);
    rd(A_CTRL, d); chk(d == 32'd2, "R10", "control shows error", d, 2);
    repeat (3) @(negedge clk);
    chk(err, "R10", "error sticky", err, 1);
    wr(A_JSEL_LO, 32'hFFFFFFF4);
    wr(A_CTRL, 32'd1);
    chk(!err, "R10", "error cleared by start", err, 0);
    walk(n, tr, cyc, fd, fok);
    chk(fd && tr == 32'h40, "R4", "walk after error", tr, 32'h40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule